// File: doc/BRIEF.md
# Four-Channel Sampling Converter Sequencer

This block sits on the host side of a converter that samples up to four analog inputs at the same instant and then converts them one after another. When the host raises `start_i` with a non-zero set of enabled channels, the sequencer pulses the convert-start line. It then watches the converter's active-low end-of-conversion line. Each time that line falls, it fetches one word over a 12-bit parallel bus using an active-low read strobe, and an optional chip select that may be held permanently low. Each result is read while its conversion is freshly finished, before the next one completes, so the bus never limits throughput.

Results leave the block one at a time. Each carries a channel number in ascending order of the enabled channels, a one-cycle valid pulse, and a done pulse that comes with the last result. The converter's first-word flag is checked on the first read of every sequence. If the flag is low, the sequence is flagged as misaligned and none of its words are labelled. After the final read, a quiet interval is kept before another conversion may start. The interval is given in nanoseconds and rounded up to whole clock cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and when idle after reset: `cnv_start_o`=0, `rd_n_o`=1, `cs_n_o`=1 (with the default `CS_TIED`=0), and `res_valid_o`, `done_o` and `align_err_o` are 0.
- R2: A `start_i` sampled high while idle with a non-zero `chan_en_i` raises `cnv_start_o` for exactly `CNV_CYC` cycles (default 4). A `start_i` with `chan_en_i`=0 produces no pulse.
- R3: Exactly one read is made per falling edge of `eoc_n_i` seen after the convert pulse. A sequence makes as many reads as there are set bits in `chan_en_i`, and no read overlaps `cnv_start_o`.
- R4: Every read holds `rd_n_o` low for exactly `RD_CYC` cycles (default 3). The word on `data_i` during the last low cycle is the one captured as `rd_n_o` returns high.
- R5: The k-th read of a sequence (k from 0) yields a one-cycle `res_valid_o` in the cycle after `rd_n_o` rises. `res_chan_o` is the bit position of the k-th lowest set bit of `chan_en_i`, and `res_data_o` is the captured word.
- R6: `done_o` pulses for one cycle together with the result of the last read of a sequence.
- R7: If `first_i` is low on the first read of a sequence, `align_err_o` pulses for one cycle and no `res_valid_o` occurs for the rest of that sequence. `done_o` still pulses, and the next sequence is labelled normally.
- R8: After the last read, `cnv_start_o` cannot rise until `rd_n_o` has been high for at least QUIET = ceil(`QUIET_NS`/`CLK_NS`) cycles (25 by default). A trigger taken during that interval is held and served once it ends.
- R9: With `CS_TIED`=0, `cs_n_o` is low from the convert pulse through the last read and high otherwise. With `CS_TIED`=1 it is held low.
- R10: `start_i` pulses while a sequence is in progress are ignored: no extra convert pulse and no change to the enabled channel set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a conversion sequence |
| chan_en_i | input | NCH | Enabled channels, bit i for channel i |
| cnv_start_o | output | 1 | Convert-start pulse, conversion begins on its rising edge |
| eoc_n_i | input | 1 | Active-low end-of-conversion from the converter |
| first_i | input | 1 | High when the word on the bus is the first channel's result |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| data_i | input | DW | Parallel result bus |
| res_valid_o | output | 1 | One-cycle result valid |
| res_chan_o | output | $clog2(NCH) | Channel number of the result |
| res_data_o | output | DW | Result word |
| done_o | output | 1 | Pulses with the last result of a sequence |
| align_err_o | output | 1 | Pulses when the first word was not flagged as first |

## Verification
A fault in the read index or in the channel map shows up as a wrong `res_chan_o` as early as the second result of a sequence. It is visible within one sequence, for any mask with more than one bit set. A fault in the strobe counter changes the `rd_n_o` low width on the very first read. A quiet timer that loads short or clears early shows only at the next convert-start, so back-to-back triggers are needed to expose it. A misalignment latch that does not clear appears as missing valids in the sequence that follows a misaligned one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_CNV,
      ST_WAIT,
      ST_READ
   } seq_st_t;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/adc_chan_map.sv
module adc_chan_map #(
   parameter int NCH = 4,
   localparam int CIW = $clog2(NCH),
   localparam int CW  = $clog2(NCH + 1)
) (
   input  logic [NCH-1:0] mask_i,
   input  logic [CIW-1:0] idx_i,
   output logic [CIW-1:0] chan_o,
   output logic           last_o
);

   logic [CW-1:0] seen;

   // k-th lowest set bit of the mask, and whether k is the final one
   always_comb begin
      seen   = '0;
      chan_o = '0;
      for (int i = 0; i < NCH; i++) begin
         if (mask_i[i]) begin
            if (seen == CW'(idx_i)) chan_o = CIW'(i);
            seen = seen + CW'(1);
         end
      end
      last_o = (seen == (CW'(idx_i) + CW'(1)));
   end

   always_comb begin
      if (last_o) assert_last_in_mask_R3 : assert (mask_i[chan_o]);
   end

endmodule

// File: rtl/adc_rd_strobe.sv
module adc_rd_strobe #(
   parameter int RD_CYC = 3,
   localparam int CNT_W = $clog2(RD_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic active_o,
   output logic fire_o
);

   if (RD_CYC < 1) begin : g_bad_rd
      $error("RD_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   assign fire_o = active_o && (cnt_q == CNT_W'(RD_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         cnt_q    <= '0;
      end else if (go_i) begin
         active_o <= 1'b1;
         cnt_q    <= '0;
      end else if (active_o) begin
         if (fire_o) active_o <= 1'b0;
         else        cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   // independent width monitor for the strobe
   logic [CNT_W-1:0] low_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        low_q <= '0;
      else if (active_o) low_q <= low_q + CNT_W'(1);
      else               low_q <= '0;
   end

   assert_rd_width_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> (low_q == CNT_W'(RD_CYC)));

endmodule

// File: rtl/adc_quiet_timer.sv
module adc_quiet_timer #(
   parameter int QCYC = 25,
   localparam int QW = $clog2(QCYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic clear_o
);

   if (QCYC < 1) begin : g_bad_q
      $error("QCYC must be at least 1");
   end

   logic [QW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= QW'(QCYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - QW'(1);
   end

   assign clear_o = (cnt_q == '0);

   assert_quiet_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !clear_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int DW       = 12,
   parameter int CLK_NS   = 4,
   parameter int QUIET_NS = 100,
   parameter int CNV_CYC  = 4,
   parameter int RD_CYC   = 3,
   parameter bit CS_TIED  = 1'b0,
   localparam int CIW       = $clog2(NCH),
   localparam int QUIET_CYC = int'(ceil_div(QUIET_NS, CLK_NS)),
   localparam int CCW       = $clog2(CNV_CYC + 1),
   localparam int GW        = $clog2(QUIET_CYC + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [NCH-1:0] chan_en_i,
   output logic           cnv_start_o,
   input  logic           eoc_n_i,
   input  logic           first_i,
   output logic           cs_n_o,
   output logic           rd_n_o,
   input  logic [DW-1:0]  data_i,
   output logic           res_valid_o,
   output logic [CIW-1:0] res_chan_o,
   output logic [DW-1:0]  res_data_o,
   output logic           done_o,
   output logic           align_err_o
);

   if (NCH < 2) begin : g_bad_nch
      $error("NCH must be at least 2");
   end
   if (QUIET_NS < 50 || QUIET_NS > 100) begin : g_bad_quiet
      $error("QUIET_NS must lie between 50 and 100");
   end
   if (CNV_CYC < 1 || CLK_NS < 1 || DW < 1) begin : g_bad_misc
      $error("CNV_CYC, CLK_NS and DW must be positive");
   end

   seq_st_t        st_q;
   logic [NCH-1:0] mask_q;
   logic [CIW-1:0] idx_q;
   logic [CCW-1:0] cnv_cnt_q;
   logic           bad_q;
   logic           eoc_q;
   logic           eoc_fall;
   logic           rd_go, rd_active, rd_fire;
   logic           quiet_clear;
   logic [CIW-1:0] map_chan;
   logic           map_last;
   logic           first_rd, misaligned, seq_bad;

   assign eoc_fall   = eoc_q && !eoc_n_i;
   assign rd_go      = (st_q == ST_WAIT) && eoc_fall;
   assign first_rd   = (idx_q == '0);
   assign misaligned = first_rd && !first_i;
   assign seq_bad    = bad_q || misaligned;

   adc_chan_map #(.NCH(NCH)) u_map (
      .mask_i (mask_q),
      .idx_i  (idx_q),
      .chan_o (map_chan),
      .last_o (map_last)
   );

   adc_rd_strobe #(.RD_CYC(RD_CYC)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (rd_go),
      .active_o (rd_active),
      .fire_o   (rd_fire)
   );

   adc_quiet_timer #(.QCYC(QUIET_CYC)) u_quiet (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (rd_fire && map_last),
      .clear_o (quiet_clear)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) eoc_q <= 1'b1;
      else        eoc_q <= eoc_n_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         mask_q      <= '0;
         idx_q       <= '0;
         cnv_cnt_q   <= '0;
         bad_q       <= 1'b0;
         res_valid_o <= 1'b0;
         res_chan_o  <= '0;
         res_data_o  <= '0;
         done_o      <= 1'b0;
         align_err_o <= 1'b0;
      end else begin
         res_valid_o <= 1'b0;
         done_o      <= 1'b0;
         align_err_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i && (chan_en_i != '0)) begin
                  mask_q <= chan_en_i;
                  st_q   <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (quiet_clear) begin
                  st_q      <= ST_CNV;
                  cnv_cnt_q <= '0;
                  idx_q     <= '0;
                  bad_q     <= 1'b0;
               end
            end
            ST_CNV: begin
               if (cnv_cnt_q == CCW'(CNV_CYC - 1)) st_q <= ST_WAIT;
               else cnv_cnt_q <= cnv_cnt_q + CCW'(1);
            end
            ST_WAIT: begin
               if (eoc_fall) st_q <= ST_READ;
            end
            ST_READ: begin
               if (rd_fire) begin
                  bad_q       <= seq_bad;
                  res_valid_o <= !seq_bad;
                  res_chan_o  <= map_chan;
                  res_data_o  <= data_i;
                  align_err_o <= misaligned;
                  done_o      <= map_last;
                  if (map_last) begin
                     st_q <= ST_IDLE;
                  end else begin
                     idx_q <= idx_q + CIW'(1);
                     st_q  <= ST_WAIT;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cnv_start_o = (st_q == ST_CNV);
   assign rd_n_o      = !rd_active;

   if (CS_TIED) begin : g_cs_tied
      assign cs_n_o = 1'b0;
   end else begin : g_cs_seq
      assign cs_n_o = !((st_q == ST_CNV) || (st_q == ST_WAIT) || (st_q == ST_READ));

      assert_cs_covers_rd_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         !rd_n_o |-> !cs_n_o);
   end

   // cycles with the read strobe high since the latest read, saturating
   logic [GW-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                      gap_q <= GW'(QUIET_CYC);
      else if (!rd_n_o)                gap_q <= '0;
      else if (gap_q != GW'(QUIET_CYC)) gap_q <= gap_q + GW'(1);
   end

   assert_quiet_gap_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_start_o) |-> (gap_q == GW'(QUIET_CYC)));

   assert_no_rd_in_cnv_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(cnv_start_o && !rd_n_o));

   assert_err_blocks_valid_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      align_err_o |-> !res_valid_o);

   assert_done_single_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_valid_after_rd_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> $rose(rd_n_o));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

   localparam int NCH = 4;
   localparam int DW = 12;
   localparam int CNV_CYC = 4;
   localparam int RD_CYC = 3;
   localparam int QUIET = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [NCH-1:0] chan_en_i = '0;
   logic cnv_start_o, cs_n_o, rd_n_o;
   logic eoc_n_i = 1'b1;
   logic first_i;
   logic [DW-1:0] data_i;
   logic res_valid_o, done_o, align_err_o;
   logic [1:0] res_chan_o;
   logic [DW-1:0] res_data_o;

   always #2 clk = ~clk;

   adc_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_en_i(chan_en_i),
      .cnv_start_o(cnv_start_o), .eoc_n_i(eoc_n_i), .first_i(first_i),
      .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .data_i(data_i),
      .res_valid_o(res_valid_o), .res_chan_o(res_chan_o), .res_data_o(res_data_o),
      .done_o(done_o), .align_err_o(align_err_o)
   );

   // converter model: word pointer advances on each read strobe rise
   int ptr = 0;
   int base = 0;
   int seq_id = 0;
   logic force_bad = 1'b0;
   logic [NCH-1:0] cur_mask = '0;
   logic [3:0] eff;

   assign eff     = 4'(ptr - base);
   assign data_i  = {4'(seq_id), 4'hA, eff};
   assign first_i = (eff == 4'd0) && !force_bad;

   always @(posedge rd_n_o) ptr = ptr + 1;

   always @(posedge cnv_start_o) begin
      base = ptr;
      for (int k = 0; k < $countones(cur_mask); k++) begin
         repeat (12) @(negedge clk);
         eoc_n_i = 1'b0;
         repeat (3) @(negedge clk);
         eoc_n_i = 1'b1;
      end
   end

   // port monitor
   int cnv_rises = 0, cnv_hi = 0, cnv_w = 0;
   int rd_lo = 0, rd_rises = 0, rd_w_bad = 0;
   int since_rd = 1000, gap_min = 1000;
   int vcnt = 0, done_cnt = 0, err_cnt = 0, cs_bad = 0, v_at_done = 0;
   logic [1:0] vchan [8];
   logic [DW-1:0] vdata [8];
   logic prev_cnv = 1'b0, prev_rd = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cnv_start_o) begin
            if (!prev_cnv) begin
               cnv_rises++;
               if (since_rd < gap_min) gap_min = since_rd;
            end
            cnv_hi++;
            if (cs_n_o) cs_bad++;
         end else if (prev_cnv) begin
            cnv_w = cnv_hi;
            cnv_hi = 0;
         end
         if (!rd_n_o) begin
            rd_lo++;
            since_rd = 0;
            if (cs_n_o) cs_bad++;
         end else begin
            if (!prev_rd) begin
               rd_rises++;
               if (rd_lo != RD_CYC) rd_w_bad++;
               rd_lo = 0;
            end
            since_rd++;
         end
         if (res_valid_o && vcnt < 8) begin
            vchan[vcnt] = res_chan_o;
            vdata[vcnt] = res_data_o;
            vcnt++;
         end
         if (done_o) begin
            done_cnt++;
            v_at_done = vcnt;
         end
         if (align_err_o) err_cnt++;
         prev_cnv = cnv_start_o;
         prev_rd  = rd_n_o;
      end
   end

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      cnv_rises = 0; cnv_w = 0; rd_rises = 0; rd_w_bad = 0; gap_min = 1000;
      vcnt = 0; done_cnt = 0; err_cnt = 0; cs_bad = 0; v_at_done = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_done();
      int t = 0;
      while (done_cnt == 0 && t < 3000) begin
         tick();
         t++;
      end
      chk(done_cnt == 1, "R6 done count", done_cnt, 1);
   endtask

   // {misaligned, expected valid count, channel mask}
   localparam int NV = 9;
   localparam logic [7:0] VEC [NV] = '{
      8'h4F, 8'h11, 8'h18, 8'h2A, 8'h26, 8'h8F, 8'h25, 8'h37, 8'h8B
   };

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (5) tick();
      chk(cnv_start_o == 1'b0, "R1 cnv in reset", int'(cnv_start_o), 0);
      chk(rd_n_o == 1'b1 && cs_n_o == 1'b1, "R1 strobes in reset", int'({rd_n_o, cs_n_o}), 3);
      chk({res_valid_o, done_o, align_err_o} == 3'b000, "R1 flags in reset",
          int'({res_valid_o, done_o, align_err_o}), 0);
      rst_n = 1'b1;
      repeat (3) tick();
      chk(cs_n_o == 1'b1 && rd_n_o == 1'b1 && !cnv_start_o, "R1 idle outputs",
          int'({cs_n_o, rd_n_o, cnv_start_o}), 6);

      // R2: empty mask is ignored
      clear_mon();
      chan_en_i = '0;
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
      repeat (30) tick();
      chk(cnv_rises == 0, "R2 empty mask no pulse", cnv_rises, 0);

      // table walk: sequences back to back so each start lands in the quiet window (R8)
      for (int i = 0; i < NV; i++) begin
         logic [NCH-1:0] m;
         logic bad;
         int nv, n, k;
         m   = VEC[i][3:0];
         nv  = int'(VEC[i][6:4]);
         bad = VEC[i][7];
         clear_mon();
         cur_mask  = m;
         force_bad = bad;
         seq_id    = i;
         chan_en_i = m;
         start_i   = 1'b1;
         tick();
         start_i = 1'b0;
         wait_done();
         n = $countones(m);
         chk(cnv_rises == 1, "R2 one convert pulse", cnv_rises, 1);
         chk(cnv_w == CNV_CYC, "R2 convert width", cnv_w, CNV_CYC);
         chk(rd_rises == n, "R3 reads per sequence", rd_rises, n);
         chk(rd_w_bad == 0, "R4 read strobe width", rd_w_bad, 0);
         chk(vcnt == nv, "R5 R7 valid count", vcnt, nv);
         chk(v_at_done == nv, "R6 done with last result", v_at_done, nv);
         chk(err_cnt == int'(bad), "R7 alignment error", err_cnt, int'(bad));
         chk(cs_bad == 0, "R9 chip select during sequence", cs_bad, 0);
         chk(gap_min >= QUIET, "R8 quiet gap", gap_min, QUIET);
         k = 0;
         for (int b = 0; b < NCH; b++) begin
            if (m[b] && !bad && k < vcnt) begin
               chk(vchan[k] == 2'(b), "R5 channel label", int'(vchan[k]), b);
               chk(vdata[k] == {4'(i), 4'hA, 4'(k)}, "R4 R5 captured word",
                   int'(vdata[k]), int'({4'(i), 4'hA, 4'(k)}));
               k++;
            end
         end
      end

      // R10: re-trigger while busy is ignored
      repeat (40) tick();
      clear_mon();
      cur_mask  = 4'hF;
      force_bad = 1'b0;
      seq_id    = 12;
      chan_en_i = 4'hF;
      start_i   = 1'b1;
      tick();
      start_i = 1'b0;
      while (cnv_rises == 0) tick();
      repeat (5) tick();
      chan_en_i = 4'h1;
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
      wait_done();
      repeat (60) tick();
      chk(cnv_rises == 1, "R10 busy trigger ignored", cnv_rises, 1);
      chk(vcnt == 4, "R10 mask kept", vcnt, 4);
      chk(vcnt == 4 && vchan[3] == 2'd3, "R10 last channel", int'(vchan[3]), 3);
      chk(cs_n_o == 1'b1 && rd_n_o == 1'b1, "R9 idle chip select", int'({cs_n_o, rd_n_o}), 3);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule